// File: doc/BRIEF.md
# Inter-Processor Interrupt Trigger

This block turns one 32-bit register write into software interrupts for a set of CPU interfaces. A write names an interrupt ID from 0 to 15 and a 16-bit bitmap of target interfaces in physical numbering. The block raises that ID in the private pending state of every target it names. Each target keeps a separate pending bit for every possible sender, so a later acknowledge can report which CPU raised the interrupt. These IDs are always edge events: each write sets bits and never holds them.

The port that acknowledges the interrupt picks a target interface and an ID. It returns, in the same cycle, whether anything is pending and the lowest-numbered sender, and it clears only that sender's bit on the next clock edge. A write takes effect only while the distributor's global enable input is high.

Top module: `ipi_trigger`

## Requirements
- R1: After reset, every bit of `pend_o` is 0 and an acknowledge returns `ack_hit_o`=0.
- R2: A write with `dist_en_i`=1 and `wr_src_i`=s takes its ID from bits [3:0] and its target bitmap from bits [23:8], where bit 8+t selects interface t. For each selected t, the write sets pending(t, ID, s) on the next clock edge. `pend_o[t*16+ID]` shows whether any sender is pending for that target and ID.
- R3: A write while `dist_en_i`=0 changes no pending state.
- R4: A write whose bits [23:8] are all zero changes no pending state.
- R5: Bits [7:4] and [31:24] of the write data are ignored, and so are target bits for interfaces numbered NUM_CPU or higher.
- R6: An acknowledge (`ack_valid_i`=1, `ack_cpu_i`, `ack_id_i`) on a pending pair gives `ack_hit_o`=1 and `ack_src_o` = the lowest-numbered pending sender in the same cycle. Only that sender's bit is cleared on the next edge, so the bits of other senders stay set.
- R7: An acknowledge of a pair with nothing pending gives `ack_hit_o`=0 and `ack_src_o`=0, and changes no state.
- R8: If a write sets the same bit that an acknowledge clears in the same cycle, the bit ends up set.
- R9: The pending state of each target is its own: a write or acknowledge for one interface leaves the others untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dist_en_i | input | 1 | Distributor global enable |
| wr_en_i | input | 1 | Trigger register write strobe |
| wr_data_i | input | 32 | Write data: ID at [3:0], targets at [23:8] |
| wr_src_i | input | CW | Number of the CPU issuing the write |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_cpu_i | input | CW | Interface being acknowledged |
| ack_id_i | input | 4 | ID being acknowledged |
| ack_hit_o | output | 1 | A sender was pending for the acknowledged pair |
| ack_src_o | output | CW | Lowest-numbered pending sender |
| pend_o | output | NUM_CPU*16 | Per-interface, per-ID pending summary |

## Verification
A wrong pending bit shows on `pend_o` one edge after the write or acknowledge that caused it, and on `ack_src_o` in the very cycle that pair is next acknowledged. A lost sender bit appears as an early `ack_hit_o`=0 partway through draining several senders. A bit cleared in the wrong place appears as a missing pending bit on an unrelated target or ID. For this reason the bench drains every multi-sender pair one acknowledge at a time and compares the whole pending vector after every cycle.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int ID_N   = 16;
  localparam int ID_W   = 4;
  localparam int TGT_LSB = 8;
  localparam int TGT_W  = 16;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CW      = $clog2(NUM_CPU)
) (
  input  logic                                       clk_i,
  input  logic                                       rst_ni,
  input  logic                                       dist_en_i,
  input  logic                                       wr_en_i,
  input  logic [31:0]                                wr_data_i,
  input  logic [CW-1:0]                              wr_src_i,
  output logic [NUM_CPU-1:0][ID_N-1:0][NUM_CPU-1:0]  set_o
);
  logic [ID_W-1:0]  id;
  logic [TGT_W-1:0] tgt;
  logic             fire;

  assign id   = wr_data_i[ID_W-1:0];
  assign tgt  = wr_data_i[TGT_LSB +: TGT_W];
  assign fire = wr_en_i && dist_en_i && (int'(wr_src_i) < NUM_CPU);

  always_comb begin
    set_o = '0;
    if (fire) begin
      for (int t = 0; t < NUM_CPU; t++) begin
        if (t < TGT_W && tgt[t]) set_o[t][id][wr_src_i] = 1'b1;
      end
    end
  end

  AST_ONE_BIT_PER_TGT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(set_o) <= NUM_CPU); // R5
  AST_DIS_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dist_en_i |-> set_o == '0); // R3
endmodule

// File: rtl/ipi_bank.sv
module ipi_bank
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CW      = $clog2(NUM_CPU)
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [ID_N-1:0][NUM_CPU-1:0]    set_i,
  input  logic                            ack_en_i,
  input  logic [ID_W-1:0]                 ack_id_i,
  output logic                            ack_hit_o,
  output logic [CW-1:0]                   ack_src_o,
  output logic [ID_N-1:0]                 pend_o
);
  logic [ID_N-1:0][NUM_CPU-1:0] pend_q, clr;
  logic [NUM_CPU-1:0]           row;
  logic                         any;
  logic [CW-1:0]                low;

  assign row = pend_q[ack_id_i];

  always_comb begin
    any = 1'b0;
    low = '0;
    for (int s = NUM_CPU - 1; s >= 0; s--) begin
      if (row[s]) begin
        any = 1'b1;
        low = CW'(s);
      end
    end
  end

  assign ack_hit_o = ack_en_i && any;
  assign ack_src_o = ack_hit_o ? low : '0;

  always_comb begin
    clr = '0;
    if (ack_hit_o) clr[ack_id_i][low] = 1'b1;
  end

  // set after clear: a same-cycle retrigger survives the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr) | set_i;
  end

  for (genvar i = 0; i < ID_N; i++) begin : g_sum
    assign pend_o[i] = |pend_q[i];
  end

  AST_SET_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i))); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit_o && !set_i[ack_id_i][ack_src_o])
      |=> !pend_q[$past(ack_id_i)][$past(ack_src_o)]); // R6
  AST_HIT_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_hit_o |-> pend_o[ack_id_i]); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0 && !ack_hit_o) |=> $stable(pend_q)); // R7
endmodule

// File: rtl/ipi_trigger.sv
module ipi_trigger
  import ipi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CW      = $clog2(NUM_CPU)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      dist_en_i,
  input  logic                      wr_en_i,
  input  logic [31:0]               wr_data_i,
  input  logic [CW-1:0]             wr_src_i,
  input  logic                      ack_valid_i,
  input  logic [CW-1:0]             ack_cpu_i,
  input  logic [ID_W-1:0]           ack_id_i,
  output logic                      ack_hit_o,
  output logic [CW-1:0]             ack_src_o,
  output logic [NUM_CPU*ID_N-1:0]   pend_o
);
  logic [NUM_CPU-1:0][ID_N-1:0][NUM_CPU-1:0] set;
  logic [NUM_CPU-1:0]                        hit;
  logic [NUM_CPU-1:0][CW-1:0]                src;

  ipi_decode #(.NUM_CPU(NUM_CPU), .CW(CW)) u_dec (
    .clk_i, .rst_ni, .dist_en_i, .wr_en_i, .wr_data_i, .wr_src_i,
    .set_o(set)
  );

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    ipi_bank #(.NUM_CPU(NUM_CPU), .CW(CW)) u_bank (
      .clk_i, .rst_ni,
      .set_i(set[c]),
      .ack_en_i(ack_valid_i && int'(ack_cpu_i) == c),
      .ack_id_i,
      .ack_hit_o(hit[c]),
      .ack_src_o(src[c]),
      .pend_o(pend_o[c*ID_N +: ID_N])
    );
  end

  always_comb begin
    ack_src_o = '0;
    for (int c = 0; c < NUM_CPU; c++) ack_src_o |= src[c];
  end
  assign ack_hit_o = |hit;

  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dist_en_i && !ack_valid_i) |=> $stable(pend_o)); // R3
  AST_ZERO_TGT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data_i[TGT_LSB +: TGT_W] == '0 && !ack_valid_i) |=> $stable(pend_o)); // R4
  AST_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit)); // R9
endmodule

// File: tb/tb_ipi_trigger.sv
module tb_ipi_trigger;
  localparam int N  = 8;
  localparam int CW = 3;

  logic clk = 0, rst_n = 0;
  logic dist_en = 0, wr_en = 0, ack_v = 0;
  logic [31:0] wr_data = '0;
  logic [CW-1:0] wr_src = '0, ack_cpu = '0, src_o;
  logic [3:0] ack_id = '0;
  logic hit_o;
  logic [N*16-1:0] pend_o;

  bit model [N][16][N];
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  ipi_trigger #(.NUM_CPU(N), .CW(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dist_en_i(dist_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wr_src_i(wr_src), .ack_valid_i(ack_v),
    .ack_cpu_i(ack_cpu), .ack_id_i(ack_id), .ack_hit_o(hit_o),
    .ack_src_o(src_o), .pend_o(pend_o)
  );

  function automatic logic [N*16-1:0] exp_pend();
    logic [N*16-1:0] v = '0;
    for (int t = 0; t < N; t++)
      for (int i = 0; i < 16; i++)
        for (int s = 0; s < N; s++) if (model[t][i][s]) v[t*16+i] = 1'b1;
    return v;
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: optional write and optional acknowledge, then compare
  task automatic cyc(string req, bit en, bit w, logic [31:0] d, int s,
                     bit a, int ac, int ai);
    bit eh = 0;
    int es = 0;
    dist_en = en; wr_en = w; wr_data = d; wr_src = CW'(s);
    ack_v = a; ack_cpu = CW'(ac); ack_id = 4'(ai);
    #1;
    if (a) begin
      for (int k = N - 1; k >= 0; k--) if (model[ac][ai][k]) begin eh = 1; es = k; end
      chk({req, " ack_hit"}, 128'(hit_o), 128'(eh));
      chk({req, " ack_src"}, 128'(src_o), 128'(es));
      if (eh) model[ac][ai][es] = 0;
    end
    if (w && en && d[23:8] != 0)
      for (int t = 0; t < N; t++) if (d[8+t]) model[t][d[3:0]][s] = 1;
    @(negedge clk);
    wr_en = 0; ack_v = 0;
    chk({req, " pend"}, 128'(pend_o), 128'(exp_pend()));
  endtask

  task automatic t_reset();
    chk("R1 pend", 128'(pend_o), 128'(0));
    cyc("R1", 1, 0, 0, 0, 1, 2, 9);
  endtask

  task automatic t_basic();
    cyc("R2", 1, 1, 32'h0000_0505, 1, 0, 0, 0);   // cpu0,cpu2 id5 from 1
    cyc("R2", 1, 1, 32'h0000_8009, 6, 0, 0, 0);   // cpu7 id9 from 6
  endtask

  task automatic t_disabled();
    cyc("R3", 0, 1, 32'h0000_0207, 2, 0, 0, 0);
  endtask

  task automatic t_zero();
    cyc("R4", 1, 1, 32'hFF00_00F4, 3, 0, 0, 0);
  endtask

  task automatic t_ignored();
    // high byte and [7:4] set, id 3, targets cpu3 plus cpu12 (absent)
    cyc("R5", 1, 1, 32'hAB10_08F3, 5, 0, 0, 0);
    chk("R5 cpu3 id3", 128'(pend_o[3*16+3]), 128'(1));
    chk("R5 cpu3 id15", 128'(pend_o[3*16+15]), 128'(0));
  endtask

  task automatic t_ack();
    cyc("R6", 1, 1, 32'h0000_0105, 4, 0, 0, 0);   // cpu0 id5 from 4
    cyc("R6", 1, 1, 32'h0000_0105, 7, 0, 0, 0);   // cpu0 id5 from 7
    cyc("R6", 1, 0, 0, 0, 1, 0, 5);               // src 1
    cyc("R6", 1, 0, 0, 0, 1, 0, 5);               // src 4
    cyc("R9", 1, 0, 0, 0, 1, 0, 5);               // src 7
    chk("R9 cpu2 id5 kept", 128'(pend_o[2*16+5]), 128'(1));
    cyc("R7", 1, 0, 0, 0, 1, 0, 5);               // empty
    cyc("R7", 0, 0, 0, 0, 1, 1, 0);               // never set
  endtask

  task automatic t_collide();
    cyc("R8", 1, 1, 32'h0000_0405, 1, 1, 2, 5);   // clear and reset cpu2/id5/src1
    chk("R8 still pending", 128'(pend_o[2*16+5]), 128'(1));
    cyc("R8", 1, 0, 0, 0, 1, 2, 5);
    cyc("R8", 1, 0, 0, 0, 1, 2, 5);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_disabled();
    t_zero();
    t_ignored();
    t_ack();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule